// File: doc/BRIEF.md
# Compact Float Immediate Loader

This unit builds a floating-point constant in a 64-bit floating-point register from 16-bit immediates, so a constant can be set up without a memory load. It has two operations. A load takes the immediate as the upper half of a single-precision word, with the lower half zero, and writes that value widened to double precision. A patch is a read-modify-write. It narrows the register's current double-precision content back to single precision and puts a second immediate into the low 16 bits of that word. It then writes the widened result. A load followed by a patch therefore gives any single-precision constant exactly.

The immediate reaches the unit in three instruction fields. The current register value comes in on a separate input, and the result leaves through a registered output with a one-cycle write strobe. No floating-point status or condition flags are read or written. Because the register already holds a double, a patch cannot just OR bits into it. It must narrow, patch and widen. This includes renormalising single-precision subnormals in both directions.

Top module: `fimm_loader`

## Requirements
- R1: The 16-bit immediate is `{imm_hi, imm_mid, imm_lsb}`: imm_hi (10 bits) fills immediate bits 15..6, imm_mid (5 bits) bits 5..1, imm_lsb bit 0.
- R2: With op_sel = 0 (load), the result is the single-precision word `{imm, 16'h0000}` widened to double. old_value has no effect.
- R3: Load immediates 0x7F80, 0xFF80, 0x7FC0, 0x8000 and 0x0000 give 0x7FF0000000000000, 0xFFF0000000000000, 0x7FF8000000000000, 0x8000000000000000 and zero.
- R4: Widening a normal single keeps the sign. It adds 896 to the 8-bit exponent to form the 11-bit exponent and appends 29 zero bits to the 23-bit fraction.
- R5: A single-precision subnormal (exponent 0, fraction not 0) widens to a normal double. The exponent is 896 minus the fraction's leading-zero count, and the fraction is shifted left until the leading one drops out.
- R6: With op_sel = 1 (patch), old_value is narrowed to single precision and its low 16 bits are replaced by the immediate. The result is widened. Example: old 0x3FF0000000000000 with 0x8000 gives 0x3FF0100000000000.
- R7: A patch keeps the sign, the exponent and the upper 7 fraction bits of the narrowed value. This holds for narrowed subnormals too. An all-ones exponent (Inf/NaN) stays all ones.
- R8: The 29 low fraction bits of old_value, which lie below single precision, have no effect on a patch.
- R9: value_out and a one-cycle wr_en pulse appear on the clock edge after an op_valid cycle. Back-to-back ops give back-to-back pulses. With op_valid low, wr_en is low and value_out holds.
- R10: While rst_n is low, value_out is zero and wr_en is low.
- R11: When narrowing, a double exponent above 1150 (and not all ones) becomes the all-ones single exponent with fraction zero. An exponent below 874 becomes a signed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = load upper half, 1 = patch lower half |
| imm_hi | input | 10 | Immediate bits 15..6 |
| imm_mid | input | 5 | Immediate bits 5..1 |
| imm_lsb | input | 1 | Immediate bit 0 |
| old_value | input | 64 | Current register content (read by a patch) |
| value_out | output | 64 | New register value |
| wr_en | output | 1 | Register write pulse |

## Verification
The hardest cases to reach are the narrowing corners of a patch. These are a double whose exponent lies in the single-precision subnormal band, one just outside the single range, and one carrying junk below single precision. A plain load-then-patch sequence never produces these. The bench therefore drives old_value directly with chosen doubles: widened subnormals, exponents 873, 1150 and 1151, NaN, and a value with its 29 low fraction bits set. It compares each result against hand-derived constants. Back-to-back strobes and idle gaps exercise the write-pulse timing.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
   typedef enum logic {
      OP_LOAD_HI  = 1'b0,
      OP_PATCH_LO = 1'b1
   } fimm_op_e;

   localparam int DEF_IMM_HI_W  = 10;
   localparam int DEF_IMM_MID_W = 5;
   localparam int DEF_IMM_LSB_W = 1;
   localparam int DEF_SP_EXP_W  = 8;
   localparam int DEF_SP_FRAC_W = 23;
   localparam int DEF_DP_EXP_W  = 11;
   localparam int DEF_DP_FRAC_W = 52;
endpackage

// File: rtl/fimm_field_join.sv
module fimm_field_join #(
   parameter int HI_W  = fimm_pkg::DEF_IMM_HI_W,
   parameter int MID_W = fimm_pkg::DEF_IMM_MID_W,
   parameter int LSB_W = fimm_pkg::DEF_IMM_LSB_W,
   localparam int IMM_W = HI_W + MID_W + LSB_W
) (
   input  logic [HI_W-1:0]  hi_f,
   input  logic [MID_W-1:0] mid_f,
   input  logic [LSB_W-1:0] lsb_f,
   output logic [IMM_W-1:0] imm
);
   // the widest field carries the most significant bits
   assign imm[IMM_W-1 -: HI_W]        = hi_f;
   assign imm[LSB_W+MID_W-1 -: MID_W] = mid_f;
   assign imm[LSB_W-1:0]              = lsb_f;
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen #(
   parameter int SP_EXP_W  = fimm_pkg::DEF_SP_EXP_W,
   parameter int SP_FRAC_W = fimm_pkg::DEF_SP_FRAC_W,
   parameter int DP_EXP_W  = fimm_pkg::DEF_DP_EXP_W,
   parameter int DP_FRAC_W = fimm_pkg::DEF_DP_FRAC_W,
   localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W,
   localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W
) (
   input  logic [SP_W-1:0] sp_in,
   output logic [DP_W-1:0] dp_out
);
   localparam int SHIFT     = DP_FRAC_W - SP_FRAC_W;
   localparam int BIAS_DIFF = (2**(DP_EXP_W-1) - 1) - (2**(SP_EXP_W-1) - 1);
   localparam int LZW       = $clog2(SP_FRAC_W + 1);

   logic                 sgn;
   logic [SP_EXP_W-1:0]  ex;
   logic [SP_FRAC_W-1:0] fr;
   assign {sgn, ex, fr} = sp_in;

   // leading-zero count as a priority chain, highest set bit wins
   logic [LZW-1:0] lz_chain [SP_FRAC_W+1];
   assign lz_chain[0] = LZW'(SP_FRAC_W);
   for (genvar g = 0; g < SP_FRAC_W; g++) begin : g_lz
      assign lz_chain[g+1] = fr[g] ? LZW'(SP_FRAC_W - 1 - g) : lz_chain[g];
   end

   logic [LZW-1:0]       lz;
   logic [LZW:0]         norm_sh;
   logic [SP_FRAC_W:0]   norm_full;
   logic [SP_FRAC_W-1:0] norm_fr;
   assign lz        = lz_chain[SP_FRAC_W];
   assign norm_sh   = {1'b0, lz} + 1'b1;
   assign norm_full = {1'b0, fr} << norm_sh;
   assign norm_fr   = norm_full[SP_FRAC_W-1:0];

   logic [DP_EXP_W-1:0]  dex;
   logic [SP_FRAC_W-1:0] dfr_top;

   always_comb begin
      if (ex == '1) begin
         dex     = '1;
         dfr_top = fr;
      end else if (ex == '0) begin
         if (fr == '0) begin
            dex     = '0;
            dfr_top = '0;
         end else begin
            dex     = DP_EXP_W'(BIAS_DIFF) - DP_EXP_W'(lz);
            dfr_top = norm_fr;
         end
      end else begin
         dex     = DP_EXP_W'(BIAS_DIFF) + DP_EXP_W'(ex);
         dfr_top = fr;
      end
   end

   assign dp_out = {sgn, dex, dfr_top, {SHIFT{1'b0}}};
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow #(
   parameter int SP_EXP_W  = fimm_pkg::DEF_SP_EXP_W,
   parameter int SP_FRAC_W = fimm_pkg::DEF_SP_FRAC_W,
   parameter int DP_EXP_W  = fimm_pkg::DEF_DP_EXP_W,
   parameter int DP_FRAC_W = fimm_pkg::DEF_DP_FRAC_W,
   localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W,
   localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W
) (
   input  logic [DP_W-1:0] dp_in,
   output logic [SP_W-1:0] sp_out
);
   localparam int SHIFT     = DP_FRAC_W - SP_FRAC_W;
   localparam int BIAS_DIFF = (2**(DP_EXP_W-1) - 1) - (2**(SP_EXP_W-1) - 1);
   localparam int NORM_LO   = BIAS_DIFF + 1;
   localparam int NORM_HI   = BIAS_DIFF + 2**SP_EXP_W - 2;

   logic                 sgn;
   logic [DP_EXP_W-1:0]  dex;
   logic [DP_FRAC_W-1:0] dfr;
   assign {sgn, dex, dfr} = dp_in;

   logic [SP_FRAC_W-1:0] top;
   logic                 low_bits_unused;
   assign top             = dfr[DP_FRAC_W-1 -: SP_FRAC_W];
   assign low_bits_unused = ^dfr[SHIFT-1:0];

   logic [DP_EXP_W-1:0] sub_sh;
   logic [SP_FRAC_W:0]  with_lead;
   logic [SP_FRAC_W:0]  sub_full;
   assign sub_sh    = DP_EXP_W'(NORM_LO) - dex;
   assign with_lead = {1'b1, top};
   assign sub_full  = with_lead >> sub_sh;

   logic [SP_EXP_W-1:0]  sex;
   logic [SP_FRAC_W-1:0] sfr;
   logic [DP_EXP_W-1:0]  rebased;
   assign rebased = dex - DP_EXP_W'(BIAS_DIFF);

   always_comb begin
      if (dex == '1) begin
         sex = '1;
         sfr = top;
      end else if (dex > DP_EXP_W'(NORM_HI)) begin
         sex = '1;
         sfr = '0;
      end else if (dex >= DP_EXP_W'(NORM_LO)) begin
         sex = rebased[SP_EXP_W-1:0];
         sfr = top;
      end else if (sub_sh > DP_EXP_W'(SP_FRAC_W)) begin
         sex = '0;
         sfr = '0;
      end else begin
         sex = '0;
         sfr = sub_full[SP_FRAC_W-1:0];
      end
   end

   assign sp_out = {sgn, sex, sfr};
endmodule

// File: rtl/fimm_loader.sv
module fimm_loader #(
   parameter int IMM_HI_W  = fimm_pkg::DEF_IMM_HI_W,
   parameter int IMM_MID_W = fimm_pkg::DEF_IMM_MID_W,
   parameter int IMM_LSB_W = fimm_pkg::DEF_IMM_LSB_W,
   parameter int SP_EXP_W  = fimm_pkg::DEF_SP_EXP_W,
   parameter int SP_FRAC_W = fimm_pkg::DEF_SP_FRAC_W,
   parameter int DP_EXP_W  = fimm_pkg::DEF_DP_EXP_W,
   parameter int DP_FRAC_W = fimm_pkg::DEF_DP_FRAC_W,
   localparam int IMM_W = IMM_HI_W + IMM_MID_W + IMM_LSB_W,
   localparam int SP_W  = 1 + SP_EXP_W + SP_FRAC_W,
   localparam int DP_W  = 1 + DP_EXP_W + DP_FRAC_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic                 op_sel,
   input  logic [IMM_HI_W-1:0]  imm_hi,
   input  logic [IMM_MID_W-1:0] imm_mid,
   input  logic [IMM_LSB_W-1:0] imm_lsb,
   input  logic [DP_W-1:0]      old_value,
   output logic [DP_W-1:0]      value_out,
   output logic                 wr_en
);
   import fimm_pkg::*;

   localparam int LOAD_ZERO_W = DP_FRAC_W - SP_FRAC_W + IMM_W;

   if (2 * IMM_W != SP_W) begin : g_bad_imm
      $error("immediate must be exactly half a single-precision word");
   end
   if (DP_EXP_W <= SP_EXP_W || DP_FRAC_W <= SP_FRAC_W) begin : g_bad_fmt
      $error("double format must be wider than single format");
   end
   if (IMM_HI_W < 1 || IMM_MID_W < 1 || IMM_LSB_W < 1) begin : g_bad_fld
      $error("every immediate field needs at least one bit");
   end

   fimm_op_e op;
   assign op = fimm_op_e'(op_sel);

   logic [IMM_W-1:0] imm;
   fimm_field_join #(
      .HI_W (IMM_HI_W),
      .MID_W(IMM_MID_W),
      .LSB_W(IMM_LSB_W)
   ) join_i (
      .hi_f (imm_hi),
      .mid_f(imm_mid),
      .lsb_f(imm_lsb),
      .imm  (imm)
   );

   logic [SP_W-1:0] sp_old;
   fimm_narrow #(
      .SP_EXP_W (SP_EXP_W),
      .SP_FRAC_W(SP_FRAC_W),
      .DP_EXP_W (DP_EXP_W),
      .DP_FRAC_W(DP_FRAC_W)
   ) narrow_i (
      .dp_in (old_value),
      .sp_out(sp_old)
   );

   logic [SP_W-1:0] sp_sel;
   always_comb begin
      if (op == OP_PATCH_LO) sp_sel = {sp_old[SP_W-1:IMM_W], imm};
      else                   sp_sel = {imm, {IMM_W{1'b0}}};
   end

   logic [DP_W-1:0] dp_new;
   fimm_widen #(
      .SP_EXP_W (SP_EXP_W),
      .SP_FRAC_W(SP_FRAC_W),
      .DP_EXP_W (DP_EXP_W),
      .DP_FRAC_W(DP_FRAC_W)
   ) widen_i (
      .sp_in (sp_sel),
      .dp_out(dp_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_out <= '0;
         wr_en     <= 1'b0;
      end else begin
         wr_en <= op_valid;
         if (op_valid) value_out <= dp_new;
      end
   end

   // R9
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> wr_en);
   // R9
   wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !wr_en);
   // R9
   hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(value_out));
   // R2
   load_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 1'b0) |=> (value_out[LOAD_ZERO_W-1:0] == '0));
   // R1
   load_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 1'b0) |=> (value_out[DP_W-1] == $past(imm_hi[IMM_HI_W-1])));
   // R7
   patch_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 1'b1) |=> (value_out[DP_W-1] == $past(old_value[DP_W-1])));
   // R7
   patch_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 1'b1 && (&old_value[DP_W-2 -: DP_EXP_W]))
      |=> (&value_out[DP_W-2 -: DP_EXP_W]));
endmodule

// File: tb/fimm_loader_tb_top.sv
module fimm_loader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_sel = 1'b0;
   logic [9:0]  imm_hi = '0;
   logic [4:0]  imm_mid = '0;
   logic [0:0]  imm_lsb = '0;
   logic [63:0] old_value = '0;
   logic [63:0] value_out;
   logic        wr_en;

   always #2 clk = ~clk;

   fimm_loader dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .imm_hi(imm_hi), .imm_mid(imm_mid), .imm_lsb(imm_lsb),
      .old_value(old_value), .value_out(value_out), .wr_en(wr_en)
   );

   typedef struct {
      logic [63:0] val;
      int          due;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;
   logic [63:0] last_val = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // driver: issue one op on this negedge and push its expected result
   task automatic issue(bit op, logic [15:0] imm, logic [63:0] oldv,
                        logic [63:0] expv, string tag);
      exp_t e;
      @(negedge clk);
      op_valid  = 1'b1;
      op_sel    = op;
      imm_hi    = imm[15:6];
      imm_mid   = imm[5:1];
      imm_lsb   = imm[0];
      old_value = oldv;
      e.val = expv;
      e.due = cyc + 1;
      e.tag = tag;
      sb.push_back(e);
      last_val = expv;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_valid  = 1'b0;
         old_value = 64'hDEAD_BEEF_0BAD_F00D;
         imm_hi    = 10'h3FF;
      end
   endtask

   // monitor: pop and compare whenever the design writes
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (sb.size() == 0 || sb[0].due != cyc) begin
               n_chk++; n_bad++;
               $display("FAIL R9: actual wr_en 1 expected 0 at cycle %0d", cyc);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, value_out, e.val);
            end
         end else if (sb.size() != 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++; n_bad++;
            $display("FAIL R9: actual wr_en 0 expected 1 (%s)", e.tag);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 value", value_out, 64'h0);
      check("R10 wr_en", {63'h0, wr_en}, 64'h0);
      rst_n = 1'b1;
      idle(1);

      // R2 R4 loads, old_value must not matter
      issue(0, 16'h3F80, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3FF0_0000_0000_0000, "R2 +1.0");
      issue(0, 16'hBFC0, 64'h1234_5678_9ABC_DEF0, 64'hBFF8_0000_0000_0000, "R4 -1.5");
      // R1 field placement
      issue(0, 16'h3FFF, 64'h0, 64'h3FFF_E000_0000_0000, "R1 0x3FFF");
      issue(0, 16'h4002, 64'h0, 64'h4000_4000_0000_0000, "R1 0x4002");
      // R3 special values
      issue(0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000, "R3 +inf");
      issue(0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000, "R3 -inf");
      issue(0, 16'h7FC0, 64'h0, 64'h7FF8_0000_0000_0000, "R3 qnan");
      issue(0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000, "R3 -0");
      issue(0, 16'h0000, 64'h5555_5555_5555_5555, 64'h0, "R3 +0");
      idle(2);
      // R9 hold while idle
      check("R9 hold", value_out, last_val);
      check("R9 no pulse", {63'h0, wr_en}, 64'h0);

      // R5 subnormal widening
      issue(0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000, "R5 0x0040");
      issue(0, 16'h0001, 64'h0, 64'h37A0_0000_0000_0000, "R5 0x0001");
      issue(0, 16'h0003, 64'h0, 64'h37B8_0000_0000_0000, "R5 0x0003");
      issue(1, 16'h0001, 64'h0, 64'h36A0_0000_0000_0000, "R5 patch tiny");

      // R6 patch
      issue(1, 16'h8000, 64'h3FF0_0000_0000_0000, 64'h3FF0_1000_0000_0000, "R6 1.0039");
      // R7 patch preserves upper part
      issue(1, 16'h0005, 64'h37A0_0000_0000_0000, 64'h37A0_0050_0000_0000, "R7 subnormal");
      issue(1, 16'h0001, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_2000_0000, "R7 nan");
      issue(1, 16'hFFFF, 64'hC000_0000_0000_0000, 64'hC000_1FFF_E000_0000, "R7 negative");
      // R8 bits below single ignored
      issue(1, 16'h0000, 64'h3FF0_0000_1FFF_FFFF, 64'h3FF0_0000_0000_0000, "R8 low junk");
      // R11 narrowing range edges
      issue(1, 16'h0000, 64'h47E0_0000_0000_0000, 64'h47E0_0000_0000_0000, "R11 max normal");
      issue(1, 16'h1234, 64'h47F0_0000_0000_0000, 64'h7FF0_0246_8000_0000, "R11 overflow");
      issue(1, 16'h0000, 64'h3690_0000_0000_0000, 64'h0, "R11 underflow");
      issue(1, 16'h0000, 64'hB000_0000_0000_0000, 64'h8000_0000_0000_0000, "R11 neg underflow");
      idle(3);
      check("R9 hold end", value_out, last_val);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule